// File: doc/BRIEF.md
# Register File with Deferred-Fault Poison Tags

This block is a small register file in which every entry carries a one-bit poison tag beside its data. It lets a pipeline hoist instructions above branches and mark them speculative. When such a hoisted instruction hits a fault that would end the program, no trap is taken. Its destination is instead filled with a poisoned value. The trap is taken only if a non-speculative instruction later consumes that value. A speculative consumer passes the poison on to its own destination. A check operation, left at the hoisted instruction's original place, tests one register and asks for recovery when the register is poisoned.

Each cycle the block takes at most one instruction. An instruction carries an operation kind, a speculative flag, a destination, two source indices, a result value and a fault class. The block gives back the data and poison bit of both sources at once, with bypass from the write still in flight. One cycle after an instruction is accepted, the block also gives a one-cycle fatal-exception pulse and a one-cycle recovery request. Servicing the fault, running recovery code and building the pipeline around the block are left to the caller.

Top module: `nat_regfile`

## Requirements
- R1: After reset every register reads data 0 with its poison bit clear.
- R2: An execute (`in_op`=1) with `in_spec`=1 and a terminating fault (`in_fault`=2) writes data 0 with poison 1 to its destination and gives no fatal pulse.
- R3: An execute with `in_spec`=0 and a terminating fault gives `fatal_pulse` high for one cycle on the cycle after acceptance and leaves its destination unchanged.
- R4: An execute with `in_spec`=0 that reads a poisoned register through either source gives `fatal_pulse` on the cycle after acceptance and does not write its destination.
- R5: An execute with `in_spec`=1 that reads a poisoned source writes data 0 with poison 1 to its destination and gives no fatal pulse.
- R6: A check (`in_op`=2) gives `recover_req` high on the cycle after acceptance exactly when source A is poisoned. It writes nothing and never gives a fatal pulse.
- R7: An execute without a terminating fault and with clean sources writes `in_result` to its destination and clears the destination's poison bit.
- R8: A resumable fault (`in_fault`=1) behaves like no fault. It causes no poison and no fatal pulse. Fault code 3 is also non-terminating.
- R9: Register 0 always reads data 0 and poison 0, and writes to it are dropped.
- R10: The data and poison written by an instruction are visible on both read ports in the cycle that follows its acceptance.
- R11: When `in_valid` is low, or when `in_op` is 0 or 3, the instruction changes no register and gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 2 | 0 none, 1 execute, 2 check, 3 none |
| in_spec | input | 1 | Instruction is speculative |
| in_dst | input | $clog2(NUM_REGS) | Destination index |
| in_src_a | input | $clog2(NUM_REGS) | Source A index (the tested register for a check) |
| in_src_b | input | $clog2(NUM_REGS) | Source B index |
| in_result | input | DATA_W | Result value to write |
| in_fault | input | 2 | 0 none, 1 resumable, 2 terminating, 3 none |
| rd_a_data | output | DATA_W | Source A data |
| rd_a_poison | output | 1 | Source A poison bit |
| rd_b_data | output | DATA_W | Source B data |
| rd_b_poison | output | 1 | Source B poison bit |
| fatal_pulse | output | 1 | Terminating exception raised |
| recover_req | output | 1 | Check found poison; recovery requested |

## Verification
The bench builds the block with 8 registers of 16 bits. With so few registers, random destinations and sources collide often. Poison then spreads through chains of speculative consumers, and non-speculative reads of poisoned entries come up many times in a few hundred instructions. The small register count also means that back-to-back instructions often read the register written one cycle before. This exercises the bypass path for both data and poison, and it makes register 0 show up often as both destination and source.

// File: rtl/nat_pkg.sv
package nat_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_EXEC  = 2'd1,
        OP_CHECK = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_RESUME = 2'd1,
        FLT_TERM   = 2'd2,
        FLT_RSVD   = 2'd3
    } fault_e;

    typedef struct packed {
        logic wr;
        logic pois;
        logic fatal;
        logic recover;
    } verdict_t;

    function automatic verdict_t judge(
        input op_e    op,
        input logic   spec,
        input fault_e fault,
        input logic   pa,
        input logic   pb,
        input logic   dst_nz
    );
        verdict_t v;
        logic     bad;
        bad       = pa | pb | (fault == FLT_TERM);
        v.fatal   = (op == OP_EXEC) && !spec && bad;
        v.wr      = (op == OP_EXEC) && dst_nz && !v.fatal;
        v.pois    = spec && bad;
        v.recover = (op == OP_CHECK) && pa;
        return v;
    endfunction

endpackage

// File: rtl/nat_storage.sv
module nat_storage #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32,
    parameter int NUM_RD   = 2,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          wr_pois,
    input  logic [NUM_RD-1:0][AW-1:0]     rd_addr,
    output logic [NUM_RD-1:0][DATA_W-1:0] rd_data,
    output logic [NUM_RD-1:0]             rd_pois
);
    logic [DATA_W-1:0] mem_q  [NUM_REGS];
    logic              pois_q [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                mem_q[i]  <= '0;
                pois_q[i] <= 1'b0;
            end
        end else if (wr_en && (wr_addr != '0)) begin
            mem_q[wr_addr]  <= wr_data;
            pois_q[wr_addr] <= wr_pois;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        always_comb begin
            if (rd_addr[p] == '0) begin
                rd_data[p] = '0;
                rd_pois[p] = 1'b0;
            end else if (wr_en && (wr_addr == rd_addr[p])) begin
                rd_data[p] = wr_data;
                rd_pois[p] = wr_pois;
            end else begin
                rd_data[p] = mem_q[rd_addr[p]];
                rd_pois[p] = pois_q[rd_addr[p]];
            end
        end

        AST_ZERO_REG: assert property (@(posedge clk) disable iff (rst)
            (rd_addr[p] == '0) |-> (!rd_pois[p] && rd_data[p] == '0)); // R9
    end

    AST_CLEAN_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_pois && wr_addr != '0) |=> !pois_q[$past(wr_addr)]); // R7

endmodule

// File: rtl/nat_judge.sv
module nat_judge
    import nat_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              valid,
    input  logic [1:0]        op,
    input  logic              spec,
    input  logic [1:0]        fault,
    input  logic              src_a_pois,
    input  logic              src_b_pois,
    input  logic              dst_nz,
    input  logic [DATA_W-1:0] result,
    output verdict_t          verdict,
    output logic [DATA_W-1:0] wr_data
);
    verdict_t raw;

    always_comb begin
        raw = judge(op_e'(op), spec, fault_e'(fault), src_a_pois, src_b_pois, dst_nz);
        if (!valid) raw = '0;
        verdict = raw;
        wr_data = raw.pois ? '0 : result;
    end

    AST_NO_DOUBLE: assert final (!(verdict.fatal && verdict.wr)); // R4
endmodule

// File: rtl/nat_regfile.sv
module nat_regfile
    import nat_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic              in_spec,
    input  logic [AW-1:0]     in_dst,
    input  logic [AW-1:0]     in_src_a,
    input  logic [AW-1:0]     in_src_b,
    input  logic [DATA_W-1:0] in_result,
    input  logic [1:0]        in_fault,
    output logic [DATA_W-1:0] rd_a_data,
    output logic              rd_a_poison,
    output logic [DATA_W-1:0] rd_b_data,
    output logic              rd_b_poison,
    output logic              fatal_pulse,
    output logic              recover_req
);
    localparam int NUM_RD = 2;

    logic                          wb_en_q;
    logic [AW-1:0]                 wb_addr_q;
    logic [DATA_W-1:0]             wb_data_q;
    logic                          wb_pois_q;
    logic [NUM_RD-1:0][AW-1:0]     rd_addr;
    logic [NUM_RD-1:0][DATA_W-1:0] rd_data;
    logic [NUM_RD-1:0]             rd_pois;
    verdict_t                      verdict;
    logic [DATA_W-1:0]             new_data;

    assign rd_addr[0] = in_src_a;
    assign rd_addr[1] = in_src_b;

    nat_storage #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .NUM_RD   (NUM_RD)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wb_en_q),
        .wr_addr (wb_addr_q),
        .wr_data (wb_data_q),
        .wr_pois (wb_pois_q),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .rd_pois (rd_pois)
    );

    nat_judge #(.DATA_W(DATA_W)) u_judge (
        .valid      (in_valid),
        .op         (in_op),
        .spec       (in_spec),
        .fault      (in_fault),
        .src_a_pois (rd_pois[0]),
        .src_b_pois (rd_pois[1]),
        .dst_nz     (in_dst != '0),
        .result     (in_result),
        .verdict    (verdict),
        .wr_data    (new_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_en_q     <= 1'b0;
            wb_addr_q   <= '0;
            wb_data_q   <= '0;
            wb_pois_q   <= 1'b0;
            fatal_pulse <= 1'b0;
            recover_req <= 1'b0;
        end else begin
            wb_en_q     <= verdict.wr;
            wb_addr_q   <= in_dst;
            wb_data_q   <= new_data;
            wb_pois_q   <= verdict.pois;
            fatal_pulse <= verdict.fatal;
            recover_req <= verdict.recover;
        end
    end

    assign rd_a_data   = rd_data[0];
    assign rd_a_poison = rd_pois[0];
    assign rd_b_data   = rd_data[1];
    assign rd_b_poison = rd_pois[1];

    AST_SPEC_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_spec) |=> !fatal_pulse); // R2
    AST_TRAP_SOURCE: assert property (@(posedge clk) disable iff (rst)
        fatal_pulse |-> $past(in_valid && in_op == 2'd1 && !in_spec)); // R3
    AST_RECOVER_SOURCE: assert property (@(posedge clk) disable iff (rst)
        recover_req |-> $past(in_valid && in_op == 2'd2 && rd_pois[0])); // R6
    AST_CHECK_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd2) |=> !wb_en_q); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!wb_en_q && !fatal_pulse && !recover_req)); // R11

endmodule

// File: tb/nat_regfile_test.sv
module nat_regfile_test;
    localparam int NR = 8;
    localparam int DW = 16;
    localparam int AW = $clog2(NR);

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [1:0]    in_op;
    logic          in_spec;
    logic [AW-1:0] in_dst, in_src_a, in_src_b;
    logic [DW-1:0] in_result;
    logic [1:0]    in_fault;
    logic [DW-1:0] rd_a_data, rd_b_data;
    logic          rd_a_poison, rd_b_poison, fatal_pulse, recover_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [DW-1:0] m_data [NR];
    logic          m_pois [NR];

    always #5 clk = ~clk;

    nat_regfile #(.NUM_REGS(NR), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_spec(in_spec), .in_dst(in_dst), .in_src_a(in_src_a),
        .in_src_b(in_src_b), .in_result(in_result), .in_fault(in_fault),
        .rd_a_data(rd_a_data), .rd_a_poison(rd_a_poison),
        .rd_b_data(rd_b_data), .rd_b_poison(rd_b_poison),
        .fatal_pulse(fatal_pulse), .recover_req(recover_req)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic is_term(input logic [1:0] f);
        return f == 2'd2;
    endfunction

    task automatic step(input logic v, input logic [1:0] op, input logic sp,
                        input int dst, input int sa, input int sb,
                        input logic [DW-1:0] res, input logic [1:0] flt, input string req);
        logic bad, e_fatal, e_rec;
        in_valid = v; in_op = op; in_spec = sp;
        in_dst = AW'(dst); in_src_a = AW'(sa); in_src_b = AW'(sb);
        in_result = res; in_fault = flt;
        #2;
        chk(rd_a_data == m_data[sa] && rd_a_poison == m_pois[sa], req,
            {15'd0, rd_a_poison, rd_a_data}, {15'd0, m_pois[sa], m_data[sa]});
        chk(rd_b_data == m_data[sb] && rd_b_poison == m_pois[sb], req,
            {15'd0, rd_b_poison, rd_b_data}, {15'd0, m_pois[sb], m_data[sb]});
        bad     = m_pois[sa] | m_pois[sb] | is_term(flt);
        e_fatal = v && op == 2'd1 && !sp && bad;
        e_rec   = v && op == 2'd2 && m_pois[sa];
        if (v && op == 2'd1 && !e_fatal && dst != 0) begin
            m_pois[dst] = sp && bad;
            m_data[dst] = (sp && bad) ? '0 : res;
        end
        @(posedge clk); #1;
        chk(fatal_pulse == e_fatal, req, 32'(fatal_pulse), 32'(e_fatal));
        chk(recover_req == e_rec, req, 32'(recover_req), 32'(e_rec));
    endtask

    initial begin
        #2000000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        for (int i = 0; i < NR; i++) begin m_data[i] = '0; m_pois[i] = 1'b0; end
        rst = 1'b1; in_valid = 0; in_op = 0; in_spec = 0; in_dst = 0;
        in_src_a = 0; in_src_b = 0; in_result = 0; in_fault = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: every register clean after reset
        for (int r = 0; r < NR; r++) step(0, 2'd0, 0, 0, r, r, 0, 0, "R1");
        step(1, 2'd1, 0, 1, 0, 0, 16'h1234, 0, "R7");
        step(1, 2'd1, 1, 2, 1, 0, 16'h0055, 2'd2, "R2");
        step(1, 2'd1, 0, 3, 2, 1, 16'h0066, 0, "R4 R10");
        step(1, 2'd1, 1, 4, 1, 2, 16'h0011, 0, "R5");
        step(1, 2'd2, 0, 5, 4, 0, 16'h00aa, 0, "R6");
        step(1, 2'd2, 0, 5, 1, 4, 16'h00aa, 0, "R6");
        step(1, 2'd1, 0, 5, 1, 0, 16'h0bad, 2'd2, "R3");
        step(1, 2'd1, 0, 2, 1, 0, 16'h0077, 0, "R7");
        step(1, 2'd1, 1, 6, 2, 0, 16'h0099, 2'd1, "R8");
        step(1, 2'd1, 0, 7, 6, 5, 16'h0abc, 2'd3, "R8");
        step(1, 2'd1, 1, 0, 4, 0, 16'hffff, 2'd2, "R9");
        step(1, 2'd1, 0, 0, 1, 0, 16'hfeed, 0, "R9");
        step(0, 2'd1, 1, 1, 4, 0, 16'h00ff, 2'd2, "R11");
        step(1, 2'd0, 1, 1, 4, 0, 16'h00ff, 2'd2, "R11");
        step(1, 2'd3, 0, 1, 4, 1, 16'h00ff, 0, "R11");
        step(0, 2'd0, 0, 0, 1, 0, 0, 0, "R11");
        for (int n = 0; n < 400; n++) begin
            step(($urandom % 8) != 0, 2'($urandom % 4), 1'($urandom % 2),
                 int'($urandom % NR), int'($urandom % NR), int'($urandom % NR),
                 DW'($urandom), 2'($urandom % 4), "R10 random");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule